// File: doc/BRIEF.md
# System Board Control Register Block

This block holds the I/O-mapped control logic of a 386SX-class system board. It decodes 8-bit reads and writes on a 16-bit port address. Through these ports software can fire a fast soft reset and drive the alternate A20 gate. It can route the two conventional-memory regions between on-board DRAM and the external bus, using an index/data register pair. It can switch the first serial port and the parallel port on or off and pick the parallel base address. A few plain scratch registers are also decoded.

Next to the port logic sits a combinational relocation decoder. The 384 KB of DRAM that lies behind the reserved window below 1 MB is made reachable again, starting exactly at the top of installed memory. The decoder compares each physical address against that window and returns a hit flag together with the offset into the relocated block. Read data is combinational from the port address. Writes take effect at the rising clock edge where `io_wr` is high.

Top module: `sysboard_ctl`

## Requirements
- R1: A write to port 0x0092 with data bit 0 set raises `soft_rst` for exactly the one cycle after the write edge, and a write with bit 0 clear raises no pulse. Reading 0x0092 returns the written byte with bit 0 cleared.
- R2: `a20_alt` equals bit 1 of the last byte written to port 0x0092, and is 0 after reset.
- R3: A write to port 0x00E0 latches an 8-bit index. Port 0x00E1 reads and writes the entry selected by that index in a 256-entry byte file. All entries are 0x00 after reset, and an entry keeps its value while other indices are written.
- R4: `low_int` (0x00000–0x7FFFF routed to internal DRAM) equals bit 0 of indexed entry 0. `mid_int` (0x80000–0x9FFFF) equals bit 0 of indexed entry 1. Both are 0 (external bus) after reset.
- R5: In port 0x0102, bit 2 drives `ser_en` (first serial port at 0x3F8, IRQ 4). Bit 4 enables the parallel port, and bits 6:5 give its base: 0 selects 0x3BC, 1 selects 0x378, 2 selects 0x278, and 3 leaves `par_en` low with `par_base` 0.
- R6: After reset, port 0x0102 reads 0x10, `ser_en` is 0, `par_en` is 1 with `par_base` 0x3BC, and port 0x0190 reads 0x00.
- R7: Ports 0x0094, 0x0103, 0x0104 and 0x0190 read back the last byte written to them (0x00 after reset).
- R8: Port 0x0105 stores a byte but reads it with bit 7 forced to 1.
- R9: Port 0x0091 always reads 0x00. Port 0x00E0 and any port not listed here read 0xFF.
- R10: With `mem_top` in 64 KB units, `remap_hit` is 1 exactly when `mem_top`*64K <= `mem_addr` < `mem_top`*64K + 384K. When it is 1, `remap_off` equals `mem_addr` − `mem_top`*64K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Port write strobe, one cycle per write |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| a20_alt | output | 1 | Alternate A20 gate |
| low_int | output | 1 | 0–512 KB region routed to internal DRAM |
| mid_int | output | 1 | 512–640 KB region routed to internal DRAM |
| ser_en | output | 1 | First serial port enable |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base address, 0 when disabled |
| mem_top | input | 8 | Installed memory size in 64 KB units |
| mem_addr | input | 24 | Physical address to relocate |
| remap_hit | output | 1 | Address falls in the relocated window |
| remap_off | output | 19 | Offset into the relocated 384 KB block |

## Verification
A wrong write enable or index register shows up at the routing outputs and on readback of the indexed port one cycle after the faulty write. A corrupted port-0x0102 value shows up at once on the serial and parallel enables and on the base address. A mis-decoded read or a lost forced bit is visible in the same cycle on `io_rdata`, because reads are combinational. Relocation errors are combinational too, so the bench probes both window edges and a window that extends past the top of the address space.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned PORT_W = 16;
  localparam int unsigned DATA_W = 8;

  localparam logic [PORT_W-1:0] P_ZERO   = 16'h0091;
  localparam logic [PORT_W-1:0] P_FAST   = 16'h0092;
  localparam logic [PORT_W-1:0] P_SCR94  = 16'h0094;
  localparam logic [PORT_W-1:0] P_INDEX  = 16'h00E0;
  localparam logic [PORT_W-1:0] P_DATA   = 16'h00E1;
  localparam logic [PORT_W-1:0] P_IOSEL  = 16'h0102;
  localparam logic [PORT_W-1:0] P_SCR103 = 16'h0103;
  localparam logic [PORT_W-1:0] P_SCR104 = 16'h0104;
  localparam logic [PORT_W-1:0] P_FORCE  = 16'h0105;
  localparam logic [PORT_W-1:0] P_SCR190 = 16'h0190;

  localparam logic [DATA_W-1:0] IOSEL_RST = 8'h10;
  localparam logic [DATA_W-1:0] RD_UNDEC  = 8'hFF;

  localparam logic [PORT_W-1:0] LPT_BASE0 = 16'h03BC;
  localparam logic [PORT_W-1:0] LPT_BASE1 = 16'h0378;
  localparam logic [PORT_W-1:0] LPT_BASE2 = 16'h0278;

  typedef enum logic [1:0] {
    LPT_SEL0 = 2'd0,
    LPT_SEL1 = 2'd1,
    LPT_SEL2 = 2'd2,
    LPT_NONE = 2'd3
  } lpt_sel_e;
endpackage

// File: rtl/sb_idx_file.sv
module sb_idx_file #(
  parameter int unsigned NREG = 256,
  parameter int unsigned DW   = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ent0_b0,
  output logic          ent1_b0
);
  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] ent [NREG];

  always_comb begin
    idx_d = idx_q;
    if (idx_we) idx_d = wr_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ent[i] <= '0;
    end else if (dat_we) begin
      ent[idx_q] <= wdata;
    end
  end

  assign rdata   = ent[idx_q];
  assign ent0_b0 = ent[0][0];
  assign ent1_b0 = ent[1][0];
endmodule

// File: rtl/sb_port_sel.sv
module sb_port_sel
  import sb_pkg::*;
(
  input  logic              ser_bit,
  input  logic              par_bit,
  input  logic [1:0]        par_sel,
  output logic              ser_en,
  output logic              par_en,
  output logic [PORT_W-1:0] par_base
);
  lpt_sel_e sel;

  always_comb begin
    sel      = lpt_sel_e'(par_sel);
    ser_en   = ser_bit;
    par_en   = 1'b0;
    par_base = '0;
    if (par_bit) begin
      unique case (sel)
        LPT_SEL0: begin par_en = 1'b1; par_base = LPT_BASE0; end
        LPT_SEL1: begin par_en = 1'b1; par_base = LPT_BASE1; end
        LPT_SEL2: begin par_en = 1'b1; par_base = LPT_BASE2; end
        default:  begin par_en = 1'b0; par_base = '0;        end
      endcase
    end
  end
endmodule

// File: rtl/sb_remap.sv
module sb_remap #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned GRAN_W  = 16,
  parameter int unsigned WIN_KB  = 384,
  localparam int unsigned TOP_W  = ADDR_W - GRAN_W,
  localparam int unsigned WIN_B  = WIN_KB * 1024,
  localparam int unsigned OFF_W  = $clog2(WIN_B)
) (
  input  logic [TOP_W-1:0]  top,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  logic [ADDR_W:0] base;
  logic [ADDR_W:0] diff;

  always_comb begin
    base = {1'b0, top, {GRAN_W{1'b0}}};
    diff = {1'b0, addr} - base;
    hit  = !diff[ADDR_W] && (diff[ADDR_W-1:0] < ADDR_W'(WIN_B));
    off  = diff[OFF_W-1:0];
  end
endmodule

// File: rtl/sysboard_ctl.sv
module sysboard_ctl
  import sb_pkg::*;
#(
  parameter int unsigned NREG   = 256,
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned TOP_W = ADDR_W - 16,
  localparam int unsigned OFF_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              soft_rst,
  output logic              a20_alt,
  output logic              low_int,
  output logic              mid_int,
  output logic              ser_en,
  output logic              par_en,
  output logic [15:0]       par_base,
  input  logic [TOP_W-1:0]  mem_top,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              remap_hit,
  output logic [OFF_W-1:0]  remap_off
);
  localparam int unsigned IW = $clog2(NREG);

  logic [7:0] fast_q, fast_d;
  logic [7:0] s94_q, s94_d, s103_q, s103_d, s104_q, s104_d;
  logic [7:0] f105_q, f105_d, s190_q, s190_d, iosel_q, iosel_d;
  logic       pulse_q, pulse_d;
  logic       we_fast, we_94, we_103, we_104, we_105, we_190, we_iosel;
  logic       we_idx, we_dat;
  logic [7:0] idx_rdata;

  // write strobes
  always_comb begin
    we_fast  = io_wr && (io_addr == P_FAST);
    we_94    = io_wr && (io_addr == P_SCR94);
    we_103   = io_wr && (io_addr == P_SCR103);
    we_104   = io_wr && (io_addr == P_SCR104);
    we_105   = io_wr && (io_addr == P_FORCE);
    we_190   = io_wr && (io_addr == P_SCR190);
    we_iosel = io_wr && (io_addr == P_IOSEL);
    we_idx   = io_wr && (io_addr == P_INDEX);
    we_dat   = io_wr && (io_addr == P_DATA);
  end

  // next state with explicit enables
  always_comb begin
    fast_d  = we_fast  ? {io_wdata[7:1], 1'b0} : fast_q;
    s94_d   = we_94    ? io_wdata : s94_q;
    s103_d  = we_103   ? io_wdata : s103_q;
    s104_d  = we_104   ? io_wdata : s104_q;
    f105_d  = we_105   ? io_wdata : f105_q;
    s190_d  = we_190   ? io_wdata : s190_q;
    iosel_d = we_iosel ? io_wdata : iosel_q;
    pulse_d = we_fast && io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q  <= '0;
      s94_q   <= '0;
      s103_q  <= '0;
      s104_q  <= '0;
      f105_q  <= '0;
      s190_q  <= '0;
      iosel_q <= IOSEL_RST;
      pulse_q <= 1'b0;
    end else begin
      fast_q  <= fast_d;
      s94_q   <= s94_d;
      s103_q  <= s103_d;
      s104_q  <= s104_d;
      f105_q  <= f105_d;
      s190_q  <= s190_d;
      iosel_q <= iosel_d;
      pulse_q <= pulse_d;
    end
  end

  assign soft_rst = pulse_q;
  assign a20_alt  = fast_q[1];

  sb_idx_file #(.NREG(NREG), .DW(8)) i_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_we  (we_idx),
    .dat_we  (we_dat),
    .wr_idx  (io_wdata[IW-1:0]),
    .wdata   (io_wdata),
    .rdata   (idx_rdata),
    .ent0_b0 (low_int),
    .ent1_b0 (mid_int)
  );

  sb_port_sel i_psel (
    .ser_bit  (iosel_q[2]),
    .par_bit  (iosel_q[4]),
    .par_sel  (iosel_q[6:5]),
    .ser_en   (ser_en),
    .par_en   (par_en),
    .par_base (par_base)
  );

  sb_remap #(.ADDR_W(ADDR_W), .GRAN_W(16), .WIN_KB(384)) i_remap (
    .top  (mem_top),
    .addr (mem_addr),
    .hit  (remap_hit),
    .off  (remap_off)
  );

  // read mux
  always_comb begin
    unique case (io_addr)
      P_ZERO:   io_rdata = 8'h00;
      P_FAST:   io_rdata = fast_q;
      P_SCR94:  io_rdata = s94_q;
      P_DATA:   io_rdata = idx_rdata;
      P_IOSEL:  io_rdata = iosel_q;
      P_SCR103: io_rdata = s103_q;
      P_SCR104: io_rdata = s104_q;
      P_FORCE:  io_rdata = f105_q | 8'h80;
      P_SCR190: io_rdata = s190_q;
      default:  io_rdata = RD_UNDEC;
    endcase
  end
endmodule

// File: rtl/sysboard_ctl_chk.sv
module sysboard_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        soft_rst,
  input logic        a20_alt,
  input logic        par_en,
  input logic [15:0] par_base,
  input logic        remap_hit,
  input logic [18:0] remap_off
);
  assert_pulse_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(io_wr && io_addr == 16'h0092 && io_wdata[0]));

  assert_pulse_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h0092 && io_wdata[0]) |=> soft_rst);

  assert_a20_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h0092) |=> (a20_alt == $past(io_wdata[1])));

  assert_a20_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == 16'h0092) |=> $stable(a20_alt));

  assert_lpt_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    par_en |-> (par_base == 16'h03BC || par_base == 16'h0378 || par_base == 16'h0278));

  assert_force_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 16'h0105) |-> io_rdata[7]);

  assert_zero_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 16'h0091) |-> (io_rdata == 8'h00));

  assert_off_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hit |-> (remap_off < 19'd393216));
endmodule

bind sysboard_ctl sysboard_ctl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .soft_rst  (soft_rst),
  .a20_alt   (a20_alt),
  .par_en    (par_en),
  .par_base  (par_base),
  .remap_hit (remap_hit),
  .remap_off (remap_off)
);

// File: tb/test_sysboard_ctl.sv
`timescale 1ns/1ps
module test_sysboard_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        soft_rst, a20_alt, low_int, mid_int, ser_en, par_en;
  logic [15:0] par_base;
  logic [7:0]  mem_top = 8'h10;
  logic [23:0] mem_addr = 24'h0;
  logic        remap_hit;
  logic [18:0] remap_off;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysboard_ctl i_sysboard_ctl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .soft_rst(soft_rst),
    .a20_alt(a20_alt), .low_int(low_int), .mid_int(mid_int),
    .ser_en(ser_en), .par_en(par_en), .par_base(par_base),
    .mem_top(mem_top), .mem_addr(mem_addr), .remap_hit(remap_hit),
    .remap_off(remap_off)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(16'h0102, v); check("R6 iosel reset", v, 8'h10);
    check("R6 ser_en reset", ser_en, 1'b0);
    check("R6 par_en reset", par_en, 1'b1);
    check("R6 par_base reset", par_base, 16'h03BC);
    rd(16'h0190, v); check("R6 0x190 reset", v, 8'h00);
    check("R4 low_int reset", low_int, 1'b0);
    check("R4 mid_int reset", mid_int, 1'b0);
    check("R2 a20 reset", a20_alt, 1'b0);
    check("R1 no pulse at reset", soft_rst, 1'b0);
  endtask

  task automatic t_fast_port;
    logic [7:0] v;
    wr(16'h0092, 8'h03);
    check("R1 pulse after write", soft_rst, 1'b1);
    check("R2 a20 set", a20_alt, 1'b1);
    @(negedge clk);
    check("R1 pulse one cycle", soft_rst, 1'b0);
    rd(16'h0092, v); check("R1 readback bit0 clear", v, 8'h02);
    wr(16'h0092, 8'hA4);
    check("R1 no pulse bit0 clear", soft_rst, 1'b0);
    check("R2 a20 cleared", a20_alt, 1'b0);
    rd(16'h0092, v); check("R1 readback", v, 8'hA4);
  endtask

  task automatic t_index_file;
    logic [7:0] v;
    wr(16'h00E0, 8'h00); wr(16'h00E1, 8'h01);
    check("R4 low_int on", low_int, 1'b1);
    check("R4 mid_int still off", mid_int, 1'b0);
    wr(16'h00E0, 8'h01); wr(16'h00E1, 8'h81);
    check("R4 mid_int on", mid_int, 1'b1);
    wr(16'h00E0, 8'hFF); wr(16'h00E1, 8'h5A);
    rd(16'h00E1, v); check("R3 entry 255", v, 8'h5A);
    wr(16'h00E0, 8'h01);
    rd(16'h00E1, v); check("R3 entry 1 kept", v, 8'h81);
    wr(16'h00E0, 8'h07);
    rd(16'h00E1, v); check("R3 untouched entry zero", v, 8'h00);
    wr(16'h00E0, 8'h00); wr(16'h00E1, 8'hFE);
    check("R4 low_int off", low_int, 1'b0);
    check("R4 mid_int kept", mid_int, 1'b1);
  endtask

  task automatic t_iosel;
    wr(16'h0102, 8'h34);
    check("R5 ser_en on", ser_en, 1'b1);
    check("R5 base sel1", par_base, 16'h0378);
    wr(16'h0102, 8'h50);
    check("R5 ser_en off", ser_en, 1'b0);
    check("R5 base sel2", par_base, 16'h0278);
    wr(16'h0102, 8'h70);
    check("R5 sel3 disables", par_en, 1'b0);
    check("R5 sel3 base zero", par_base, 16'h0000);
    wr(16'h0102, 8'h20);
    check("R5 bit4 clear disables", par_en, 1'b0);
    wr(16'h0102, 8'h10);
    check("R5 base sel0", par_base, 16'h03BC);
    check("R5 enabled sel0", par_en, 1'b1);
  endtask

  task automatic t_scratch;
    logic [7:0] v;
    wr(16'h0094, 8'h11); wr(16'h0103, 8'h22);
    wr(16'h0104, 8'h33); wr(16'h0190, 8'h44);
    wr(16'h0105, 8'h05);
    rd(16'h0094, v); check("R7 0x94", v, 8'h11);
    rd(16'h0103, v); check("R7 0x103", v, 8'h22);
    rd(16'h0104, v); check("R7 0x104", v, 8'h33);
    rd(16'h0190, v); check("R7 0x190", v, 8'h44);
    rd(16'h0105, v); check("R8 forced bit7", v, 8'h85);
    wr(16'h0105, 8'hC0);
    rd(16'h0105, v); check("R8 bit7 written", v, 8'hC0);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    wr(16'h0091, 8'h5A);
    rd(16'h0091, v); check("R9 0x91 zero", v, 8'h00);
    rd(16'h00E0, v); check("R9 index port undecoded read", v, 8'hFF);
    rd(16'h0093, v); check("R9 undecoded 0x93", v, 8'hFF);
    rd(16'h0106, v); check("R9 undecoded 0x106", v, 8'hFF);
  endtask

  task automatic t_remap;
    mem_top = 8'h10;
    mem_addr = 24'h0FFFFF; #1; check("R10 below miss", remap_hit, 1'b0);
    mem_addr = 24'h100000; #1; check("R10 first hit", remap_hit, 1'b1);
    check("R10 first off", remap_off, 19'h00000);
    mem_addr = 24'h15FFFF; #1; check("R10 last hit", remap_hit, 1'b1);
    check("R10 last off", remap_off, 19'h5FFFF);
    mem_addr = 24'h160000; #1; check("R10 above miss", remap_hit, 1'b0);
    mem_top = 8'hFF;
    mem_addr = 24'hFFFFFF; #1; check("R10 top hit", remap_hit, 1'b1);
    check("R10 top off", remap_off, 19'h0FFFF);
    mem_addr = 24'h000000; #1; check("R10 no wrap", remap_hit, 1'b0);
    mem_top = 8'h00;
    mem_addr = 24'h05FFFF; #1; check("R10 zero top hit", remap_hit, 1'b1);
    check("R10 zero top off", remap_off, 19'h5FFFF);
    mem_addr = 24'h060000; #1; check("R10 zero top miss", remap_hit, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_port();
    t_index_file();
    t_iosel();
    t_scratch();
    t_decode();
    t_remap();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule